// File: doc/BRIEF.md
# Flash Program Pulse Sequencer

This block produces one programming pulse for a flash array. A single start request begins a fixed order of events. A watchdog-enable output rises first and stays high for the whole pulse. A program-setup enable follows, then the program enable. The program enable is released next, then program-setup, and finally the watchdog-enable. Every gap in this order is a programmable cycle count. The length of the program enable itself is one of three programmable widths: an early width, a later width, or a width for additional programming.

A higher-level programming controller uses the block. The controller picks the width for each attempt, keeps the delay and width inputs stable, and pulses start. It then waits for the one-cycle done output before it verifies the array. The sequencer does not choose widths and does not count attempts.

Top module: `prog_pulse_seq`

## Requirements
- R1: While reset is low at a clock edge, all four outputs go low after that edge and the sequencer returns to idle.
- R2: A start accepted at an edge raises the watchdog enable alone for exactly one cycle. Program-setup then rises while the watchdog enable stays high.
- R3: Program-setup stays high alone (program low) for max(setup_dly_i,1) cycles before the program enable rises.
- R4: The program enable stays high for max(W,1) cycles. W depends on the select: W is width_early_i for select 2'b00, width_late_i for 2'b01, and width_extra_i when select bit 1 is set (2'b10 or 2'b11).
- R5: After the program enable falls, program-setup stays high for max(hold_dly_i,1) cycles.
- R6: After program-setup falls, the watchdog enable stays high alone for max(recov_dly_i,1) cycles and then falls.
- R7: A delay or width input of zero produces a one-cycle interval.
- R8: The program enable is never high unless program-setup is high.
- R9: Start is ignored from the cycle the watchdog enable rises through the cycle done is high. A start during that time neither restarts nor lengthens the sequence.
- R10: Done is high for exactly one cycle, in the first cycle in which the watchdog enable is low again.
- R11: The width select is captured when start is accepted. Changing the select during the sequence does not change the pulse width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request one pulse sequence |
| width_sel_i | input | 2 | Width select: 00 early, 01 late, 1x additional |
| setup_dly_i | input | 32 | Cycles from setup enable to program enable |
| hold_dly_i | input | 32 | Cycles from program release to setup release |
| recov_dly_i | input | 32 | Cycles from setup release to watchdog release |
| width_early_i | input | 32 | Program width for early attempts |
| width_late_i | input | 32 | Program width for later attempts |
| width_extra_i | input | 32 | Program width for additional programming |
| setup_en_o | output | 1 | Program-setup enable |
| prog_en_o | output | 1 | Program enable |
| wdog_en_o | output | 1 | Watchdog-enable window |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The outputs are decoded directly from the state register. A wrong state or a wrong next-state choice therefore shows in the very next cycle as a wrong combination of the four enables. A count loaded off by one, or taken from the wrong input, shows later: it changes the length of one interval, and the error appears at the edge where that interval should have ended. The bench compares all four outputs every cycle against a queue of expected values built when start is accepted. Both kinds of fault are caught in the cycle where they first appear.

// File: rtl/pps_pkg.sv
// Shared types for the program pulse sequencer.
// Assumes: the state encoding is internal and is never seen at the ports.
package pps_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARM,
        ST_SETUP,
        ST_PULSE,
        ST_HOLD,
        ST_RECOV,
        ST_FIN
    } pps_state_e;

    localparam int SEL_W = 2;
endpackage

// File: rtl/pps_timer.sv
// Down-counter that times one interval of the sequence.
// Assumes: load_i is given in the last cycle of the previous interval.
// A loaded value of 0 or 1 both give a one-cycle interval.
module pps_timer #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] val_i,
    output logic             expired_o
);
    localparam logic [CNT_W-1:0] ZERO = '0;
    localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] cnt_q;

    // Load the interval length less one, then count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= ZERO;
        else if (load_i)
            cnt_q <= (val_i == ZERO) ? ZERO : val_i - ONE;
        else if (cnt_q != ZERO)
            cnt_q <= cnt_q - ONE;
    end

    assign expired_o = (cnt_q == ZERO);
endmodule

// File: rtl/pps_width_sel.sv
// Captures the width select when start is accepted and picks the
// matching pulse width. Assumes the width inputs are held stable
// while a sequence runs.
module pps_width_sel #(
    parameter int CNT_W = 32,
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic [CNT_W-1:0] early_i,
    input  logic [CNT_W-1:0] late_i,
    input  logic [CNT_W-1:0] extra_i,
    output logic [SEL_W-1:0] sel_q_o,
    output logic [CNT_W-1:0] width_o
);
    logic [SEL_W-1:0] sel_q;

    // Hold the select captured at start for the rest of the sequence.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sel_q <= '0;
        else if (capture_i)
            sel_q <= sel_i;
    end

    // Bit 1 selects the additional width; otherwise bit 0 picks late over early.
    always_comb begin
        if (sel_q[1])
            width_o = extra_i;
        else if (sel_q[0])
            width_o = late_i;
        else
            width_o = early_i;
    end

    assign sel_q_o = sel_q;
endmodule

// File: rtl/pps_out_decode.sv
// Decodes the state into the four control outputs. The nesting is
// fixed here: program lies inside setup, and setup lies inside the
// watchdog window. Assumes a registered state input.
module pps_out_decode
    import pps_pkg::*;
(
    input  pps_state_e state_i,
    output logic       wdog_o,
    output logic       setup_o,
    output logic       prog_o,
    output logic       done_o
);
    // Map each state to its output combination.
    always_comb begin
        wdog_o  = 1'b0;
        setup_o = 1'b0;
        prog_o  = 1'b0;
        done_o  = 1'b0;
        unique case (state_i)
            ST_IDLE:  ;
            ST_ARM:   wdog_o = 1'b1;
            ST_SETUP: begin wdog_o = 1'b1; setup_o = 1'b1; end
            ST_PULSE: begin wdog_o = 1'b1; setup_o = 1'b1; prog_o = 1'b1; end
            ST_HOLD:  begin wdog_o = 1'b1; setup_o = 1'b1; end
            ST_RECOV: wdog_o = 1'b1;
            ST_FIN:   done_o = 1'b1;
            default:  ;
        endcase
    end
endmodule

// File: rtl/prog_pulse_seq.sv
// Program pulse sequencer top level. It steps through a watchdog
// window, program-setup, program, and the release delays, using one
// shared interval timer. Assumes the delay and width inputs are stable
// from start until done. Start is accepted only in idle.
module prog_pulse_seq
    import pps_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [SEL_W-1:0]  width_sel_i,
    input  logic [CNT_W-1:0]  setup_dly_i,
    input  logic [CNT_W-1:0]  hold_dly_i,
    input  logic [CNT_W-1:0]  recov_dly_i,
    input  logic [CNT_W-1:0]  width_early_i,
    input  logic [CNT_W-1:0]  width_late_i,
    input  logic [CNT_W-1:0]  width_extra_i,
    output logic              setup_en_o,
    output logic              prog_en_o,
    output logic              wdog_en_o,
    output logic              done_o
);
    pps_state_e       state_q, state_d;
    logic             accept;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_exp;
    logic [CNT_W-1:0] width_sel_val;
    logic [SEL_W-1:0] sel_q;

    assign accept = (state_q == ST_IDLE) && start_i;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Next state, plus the interval load for the state being entered.
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state_q)
            ST_IDLE:  if (accept) state_d = ST_ARM;
            ST_ARM: begin
                state_d  = ST_SETUP;
                tmr_load = 1'b1;
                tmr_val  = setup_dly_i;
            end
            ST_SETUP: if (tmr_exp) begin
                state_d  = ST_PULSE;
                tmr_load = 1'b1;
                tmr_val  = width_sel_val;
            end
            ST_PULSE: if (tmr_exp) begin
                state_d  = ST_HOLD;
                tmr_load = 1'b1;
                tmr_val  = hold_dly_i;
            end
            ST_HOLD: if (tmr_exp) begin
                state_d  = ST_RECOV;
                tmr_load = 1'b1;
                tmr_val  = recov_dly_i;
            end
            ST_RECOV: if (tmr_exp) state_d = ST_FIN;
            ST_FIN:   state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    pps_timer #(.CNT_W(CNT_W)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (tmr_load),
        .val_i     (tmr_val),
        .expired_o (tmr_exp)
    );

    pps_width_sel #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_width (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture_i (accept),
        .sel_i     (width_sel_i),
        .early_i   (width_early_i),
        .late_i    (width_late_i),
        .extra_i   (width_extra_i),
        .sel_q_o   (sel_q),
        .width_o   (width_sel_val)
    );

    pps_out_decode u_dec (
        .state_i (state_q),
        .wdog_o  (wdog_en_o),
        .setup_o (setup_en_o),
        .prog_o  (prog_en_o),
        .done_o  (done_o)
    );
endmodule

// File: rtl/pps_checker.sv
// Protocol checker for the program pulse sequencer, bound to the top.
// Assumes a synchronous active-low reset.
module pps_checker #(
    parameter int SEL_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wdog,
    input logic             setup,
    input logic             prog,
    input logic             done,
    input logic [SEL_W-1:0] sel_q
);
    AST_RESET_RELEASES: assert property (@(posedge clk)
        !rst_n |=> (!wdog && !setup && !prog && !done)); // R1

    AST_SETUP_IN_WDOG: assert property (@(posedge clk) disable iff (!rst_n)
        setup |-> wdog); // R2

    AST_PROG_NEEDS_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
        prog |-> setup); // R8

    AST_SETUP_OUTLIVES_PROG: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(prog) |-> setup); // R5

    AST_WDOG_OUTLIVES_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(setup) |-> wdog); // R6

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10

    AST_DONE_OUTSIDE_WDOG: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !wdog); // R10

    AST_SEL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (wdog && $past(wdog)) |-> $stable(sel_q)); // R11
endmodule

bind prog_pulse_seq pps_checker #(.SEL_W(pps_pkg::SEL_W)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .wdog  (wdog_en_o),
    .setup (setup_en_o),
    .prog  (prog_en_o),
    .done  (done_o),
    .sel_q (sel_q)
);

// File: tb/prog_pulse_seq_tb.sv
// Bench for the program pulse sequencer. A behavioural model fills a
// queue of expected output vectors {wdog,setup,prog,done} when it
// accepts a start. The bench compares the DUT with that queue every cycle.
module prog_pulse_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  sel = 2'b00;
    logic [31:0] d_setup = 32'd3, d_hold = 32'd2, d_recov = 32'd4;
    logic [31:0] w_early = 32'd5, w_late = 32'd9, w_extra = 32'd2;
    logic        setup_en, prog_en, wdog_en, done;

    int vectors = 0;
    int miscompares = 0;
    int cycles = 0;
    bit chk_en = 1'b0;

    logic [3:0] exp_q[$];
    logic [3:0] exp_cur = 4'b0000;

    always #(CLK_PERIOD/2) clk = ~clk;

    prog_pulse_seq u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start),
        .width_sel_i   (sel),
        .setup_dly_i   (d_setup),
        .hold_dly_i    (d_hold),
        .recov_dly_i   (d_recov),
        .width_early_i (w_early),
        .width_late_i  (w_late),
        .width_extra_i (w_extra),
        .setup_en_o    (setup_en),
        .prog_en_o     (prog_en),
        .wdog_en_o     (wdog_en),
        .done_o        (done)
    );

    function automatic int at_least_one(input logic [31:0] v);
        return (v == 32'd0) ? 1 : int'(v);
    endfunction

    // Behavioural model: decide the expected outputs after each edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            exp_q.delete();
            exp_cur = 4'b0000;
        end else begin
            if (exp_cur == 4'b0000 && exp_q.size() == 0 && start) begin
                int w;
                w = sel[1] ? at_least_one(w_extra) :
                    sel[0] ? at_least_one(w_late) : at_least_one(w_early);
                exp_q.push_back(4'b1000);
                for (int i = 0; i < at_least_one(d_setup); i++) exp_q.push_back(4'b1100);
                for (int i = 0; i < w; i++) exp_q.push_back(4'b1110);
                for (int i = 0; i < at_least_one(d_hold); i++) exp_q.push_back(4'b1100);
                for (int i = 0; i < at_least_one(d_recov); i++) exp_q.push_back(4'b1000);
                exp_q.push_back(4'b0001);
            end
            exp_cur = (exp_q.size() > 0) ? exp_q.pop_front() : 4'b0000;
        end
    end

    // Compare at the falling edge, away from the active edge.
    always @(negedge clk) begin
        cycles++;
        if (chk_en) begin
            logic [3:0] act;
            act = {wdog_en, setup_en, prog_en, done};
            vectors++;
            if (act !== exp_cur) begin
                miscompares++;
                if (!rst_n || $past(!rst_n))
                    $display("FAIL R1 t=%0t act=%b exp=%b", $time, act, exp_cur);
                else if (act[3] !== exp_cur[3])
                    $display("FAIL R2 R6 wdog t=%0t act=%b exp=%b", $time, act, exp_cur);
                else if (act[2] !== exp_cur[2])
                    $display("FAIL R3 R5 setup t=%0t act=%b exp=%b", $time, act, exp_cur);
                else if (act[1] !== exp_cur[1])
                    $display("FAIL R4 R7 R8 R11 prog t=%0t act=%b exp=%b", $time, act, exp_cur);
                else
                    $display("FAIL R9 R10 done t=%0t act=%b exp=%b", $time, act, exp_cur);
            end
        end
        if (cycles > WATCHDOG) begin
            miscompares++;
            $display("FAIL watchdog expired act=running exp=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    task automatic wait_idle();
        int guard = 0;
        do begin
            @(negedge clk);
            guard++;
        end while ((exp_q.size() != 0 || exp_cur != 4'b0000) && guard < 20000);
        repeat (2) @(negedge clk);
    endtask

    task automatic run_one(input logic [1:0] s);
        @(negedge clk);
        sel   = s;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_idle();
    endtask

    initial begin
        // R1: reset state
        repeat (2) @(negedge clk);
        chk_en = 1'b1;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R2 R3 R4 R5 R6: early width
        run_one(2'b00);
        // R4: late width
        run_one(2'b01);
        // R4: additional width, both encodings
        run_one(2'b10);
        run_one(2'b11);

        // R7: all intervals zero
        d_setup = 0; d_hold = 0; d_recov = 0;
        w_early = 0; w_late = 0; w_extra = 0;
        run_one(2'b00);
        run_one(2'b10);
        // R7: value one equals value zero
        d_setup = 1; d_hold = 1; d_recov = 1; w_late = 1;
        run_one(2'b01);

        // R9: start held high through a whole run, including the done cycle
        d_setup = 2; d_hold = 3; d_recov = 2;
        w_early = 4; w_late = 7; w_extra = 3;
        @(negedge clk);
        sel = 2'b01;
        start = 1'b1;
        while (exp_cur != 4'b0001) @(negedge clk);
        @(negedge clk);      // done edge passes; start still high
        @(negedge clk);      // second sequence accepted
        start = 1'b0;
        wait_idle();

        // R11: select changed right after start
        @(negedge clk);
        sel = 2'b00;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        sel = 2'b10;
        repeat (3) @(negedge clk);
        sel = 2'b01;
        wait_idle();

        // R1: reset in the middle of a pulse
        @(negedge clk);
        sel = 2'b01;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (6) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        run_one(2'b00);

        // long widths
        w_extra = 32'd300; d_recov = 32'd40;
        run_one(2'b11);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule